// File: doc/BRIEF.md
# Decode-Stage Hazard Interlock for an Eight-Stage In-Order Pipeline

This block sits beside the decode stage of an in-order pipeline that has no forwarding paths. Fetch takes two stages ahead of decode. After decode an instruction takes one of two execute paths. The short path is one execute stage followed by three data-cache stages. The long path is four stages for floating-point add/sub and for all multiplies. Both paths merge at a single writeback stage. The register file is written early in the writeback cycle and read late in the decode cycle. A consumer can therefore leave decode in the same cycle its producer is in writeback, but no earlier.

The block keeps one countdown per architectural register, giving the cycles left until the pending write to that register lands. It holds the decode instruction while any source it uses is still pending, and it inserts an empty slot into execute instead. It also keeps a small reservation vector for the shared writeback port. With this vector, and with a write-ordering check, the block stays correct when the two path latencies are configured unequal. When a branch resolves taken in execute, the block squashes the three younger stages (both fetch stages and decode) and asks fetch to redirect.

Top module: `hz_interlock`

## Requirements
- R1: Synchronous active-low reset clears every pending-write countdown, so after reset no source register causes a stall.
- R2: A producer of class short-path arithmetic (class code 0) or load (class code 1) that leaves decode with destination d makes a later reader of d wait in decode until the producer is in writeback: INT_LAT-1 stall cycles when the reader follows back-to-back.
- R3: A long-path producer (class code 4: floating-point add/sub or any multiply) makes a back-to-back reader of its destination stall LONG_LAT-1 cycles.
- R4: A reader separated from its producer by g issued instructions stalls exactly max(0, LAT-1-g) cycles. It leaves decode in the producer's writeback cycle and not one cycle later.
- R5: Register index 0 is never a hazard: writing it records nothing, and reading it never stalls.
- R6: Store (class code 2), branch (class code 3) and reserved codes 5 to 7 record no pending write. A source whose enable bit is low is never checked.
- R7: The stall output is only raised for a valid decode instruction. Whenever it is raised, the bubble output is raised too. An invalid decode slot raises neither, even when its register fields name pending registers.
- R8: In a cycle where execute reports a taken branch, both fetch flush outputs, the decode flush and the fetch redirect are all high, and the stall is low. All four are low otherwise.
- R9: A decode instruction squashed by a taken branch records no pending write. A reader of its destination in the next cycle does not stall.
- R10: A writer whose destination is still pending with more cycles left than its own latency waits until that count is no larger than its own latency, so that writes to one register land in program order.
- R11: At most one write reaches writeback per cycle. A writer whose writeback cycle is already reserved by an older write stalls until its slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_class | input | 3 | Class code: 0 arithmetic, 1 load, 2 store, 3 branch, 4 long path, 5-7 reserved |
| id_rs1 | input | IDXW | First source register index |
| id_rs1_en | input | 1 | First source is read |
| id_rs2 | input | IDXW | Second source register index |
| id_rs2_en | input | 1 | Second source is read |
| id_rd | input | IDXW | Destination register index |
| ex_br_taken | input | 1 | Branch in execute resolved taken this cycle |
| id_stall | output | 1 | Hold decode and both fetch stages |
| ex_bubble | output | 1 | Send an empty slot into execute this cycle |
| flush_if1 | output | 1 | Squash first fetch stage |
| flush_if2 | output | 1 | Squash second fetch stage |
| flush_id | output | 1 | Squash decode stage |
| fetch_redirect | output | 1 | Load fetch address with the branch target |

## Verification
The bench builds two copies of the block. The first uses the default parameters, with both path latencies at five. It covers the dependence-distance sweep, the register-zero and non-writing classes, and branch squashing. The second sets the long path to seven cycles and the short path to five. Only with these unequal latencies can a younger short write overtake an older long one, or two writes land in one writeback cycle, so only this copy reaches the write-ordering and writeback-port stalls.

// File: rtl/hz_pkg.sv
// Package: shared class codes and class decoding helpers for the interlock.
// Assumes a 3-bit class field presented by the decoder.
package hz_pkg;

    typedef enum logic [2:0] {
        CLS_ALU    = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_STORE  = 3'd2,
        CLS_BRANCH = 3'd3,
        CLS_LONG   = 3'd4,
        CLS_RSV5   = 3'd5,
        CLS_RSV6   = 3'd6,
        CLS_RSV7   = 3'd7
    } op_class_e;

    // True for classes that write a destination register.
    function automatic logic class_writes(input logic [2:0] cls);
        return (cls == CLS_ALU) || (cls == CLS_LOAD) || (cls == CLS_LONG);
    endfunction

    // True for classes routed through the long execute path.
    function automatic logic class_long(input logic [2:0] cls);
        return cls == CLS_LONG;
    endfunction

endpackage

// File: rtl/hz_scoreboard.sv
// Module: per-register countdown of cycles until the pending write lands.
// A count of 1 means the producer is in writeback now; 0 means nothing pending.
// Assumes index 0 is hard-wired and never recorded. Three combinational read ports.
module hz_scoreboard #(
    parameter int NREGS = 32,
    parameter int IDXW  = 5,
    parameter int LW    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [IDXW-1:0] set_idx,
    input  logic [LW-1:0]   set_cnt,
    input  logic [IDXW-1:0] rd_a_idx,
    input  logic [IDXW-1:0] rd_b_idx,
    input  logic [IDXW-1:0] rd_c_idx,
    output logic [LW-1:0]   rd_a_cnt,
    output logic [LW-1:0]   rd_b_cnt,
    output logic [LW-1:0]   rd_c_cnt
);

    logic [NREGS-1:0][LW-1:0] cnt_all;

    generate
        for (genvar r = 0; r < NREGS; r++) begin : g_entry
            if (r == 0) begin : g_zero
                assign cnt_all[r] = '0;
            end else begin : g_live
                logic [LW-1:0] cnt_q;
                logic          hit;

                assign hit = set_en && (set_idx == IDXW'(r));

                // Load on issue of a writer, otherwise count down to zero.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        cnt_q <= '0;
                    else if (hit)
                        cnt_q <= set_cnt;
                    else if (cnt_q != '0)
                        cnt_q <= cnt_q - 1'b1;
                end

                assign cnt_all[r] = cnt_q;

                // R1: reset leaves the entry empty.
                a_r1_reset_clear: assert property (@(posedge clk)
                    !rst_n |=> (cnt_q == '0));

                // R2: an untouched pending entry moves one step closer to writeback.
                a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
                    (cnt_q != '0 && !hit) |=> (cnt_q == $past(cnt_q) - 1'b1));
            end
        end
    endgenerate

    // Read ports for both sources and the destination.
    assign rd_a_cnt = cnt_all[rd_a_idx];
    assign rd_b_cnt = cnt_all[rd_b_idx];
    assign rd_c_cnt = cnt_all[rd_c_idx];

endmodule

// File: rtl/hz_wb_slots.sv
// Module: reservation vector for the single writeback port.
// Bit j set means a write reaches writeback j cycles from now.
// Assumes a claim with latency L lands L cycles after the issue cycle.
module hz_wb_slots #(
    parameter int MAXL = 5,
    parameter int LW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          claim_en,
    input  logic [LW-1:0] claim_lat,
    output logic          slot_busy
);

    logic [MAXL:0] occ_q;
    logic [MAXL:0] occ_d;

    // Shift the reservations one cycle closer and add a new claim.
    always_comb begin
        occ_d = occ_q >> 1;
        if (claim_en)
            occ_d[claim_lat - 1'b1] = 1'b1;
    end

    // Register the reservation vector.
    always_ff @(posedge clk) begin
        if (!rst_n)
            occ_q <= '0;
        else
            occ_q <= occ_d;
    end

    assign slot_busy = occ_q[claim_lat];

    // R11: a claim is never placed on an already reserved writeback cycle.
    a_r11_single_wb: assert property (@(posedge clk) disable iff (!rst_n)
        claim_en |-> !occ_q[claim_lat]);

    // R11: claimed latencies stay within the tracked window.
    a_r11_lat_range: assert property (@(posedge clk) disable iff (!rst_n)
        claim_en |-> (claim_lat != '0 && int'(claim_lat) <= MAXL));

endmodule

// File: rtl/hz_ctrl.sv
// Module: combinational interlock decision and branch squash controls.
// Assumes the countdown values of both sources and the destination are presented
// for the current decode instruction, plus the writeback slot state for its latency.
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int IDXW     = 5,
    parameter int LW       = 3,
    parameter int INT_LAT  = 5,
    parameter int LONG_LAT = 5
) (
    input  logic            id_valid,
    input  logic [2:0]      id_class,
    input  logic [IDXW-1:0] id_rs1,
    input  logic            id_rs1_en,
    input  logic [IDXW-1:0] id_rs2,
    input  logic            id_rs2_en,
    input  logic [IDXW-1:0] id_rd,
    input  logic            ex_br_taken,
    input  logic [LW-1:0]   rs1_cnt,
    input  logic [LW-1:0]   rs2_cnt,
    input  logic [LW-1:0]   rd_cnt,
    input  logic            slot_busy,
    output logic [LW-1:0]   lat,
    output logic            set_en,
    output logic            id_stall,
    output logic            ex_bubble,
    output logic            flush_if1,
    output logic            flush_if2,
    output logic            flush_id,
    output logic            fetch_redirect
);

    logic writes, raw1, raw2, waw, port_clash, hazard, squash, issue;

    // Classify the decode instruction and pick its writeback latency.
    always_comb begin
        writes = class_writes(id_class) && (id_rd != '0);
        lat    = class_long(id_class) ? LW'(LONG_LAT) : LW'(INT_LAT);
    end

    // Detect read-after-write, write ordering and writeback port conflicts.
    always_comb begin
        raw1       = id_rs1_en && (id_rs1 != '0) && (rs1_cnt > LW'(1));
        raw2       = id_rs2_en && (id_rs2 != '0) && (rs2_cnt > LW'(1));
        waw        = writes && (rd_cnt > lat);
        port_clash = writes && slot_busy;
        hazard     = raw1 || raw2 || waw || port_clash;
    end

    // Resolve issue, stall and bubble; a taken branch overrides the stall.
    always_comb begin
        squash    = ex_br_taken;
        id_stall  = id_valid && hazard && !squash;
        issue     = id_valid && !hazard && !squash;
        ex_bubble = id_valid && !issue;
        set_en    = issue && writes;
    end

    // Squash the three younger stages and redirect fetch on a taken branch.
    always_comb begin
        flush_if1      = squash;
        flush_if2      = squash;
        flush_id       = squash;
        fetch_redirect = squash;
    end

endmodule

// File: rtl/hz_interlock.sv
// Module: decode-stage hazard interlock, top level.
// Ties the register countdowns, the writeback slot vector and the decision logic.
// Assumes no forwarding: a source is usable only once its producer is in writeback.
module hz_interlock #(
    parameter int NREGS    = 32,
    parameter int INT_LAT  = 5,
    parameter int LONG_LAT = 5,
    localparam int IDXW    = $clog2(NREGS),
    localparam int MAXL    = (INT_LAT > LONG_LAT) ? INT_LAT : LONG_LAT,
    localparam int LW      = $clog2(MAXL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_valid,
    input  logic [2:0]      id_class,
    input  logic [IDXW-1:0] id_rs1,
    input  logic            id_rs1_en,
    input  logic [IDXW-1:0] id_rs2,
    input  logic            id_rs2_en,
    input  logic [IDXW-1:0] id_rd,
    input  logic            ex_br_taken,
    output logic            id_stall,
    output logic            ex_bubble,
    output logic            flush_if1,
    output logic            flush_if2,
    output logic            flush_id,
    output logic            fetch_redirect
);

    logic [LW-1:0] rs1_cnt, rs2_cnt, rd_cnt, lat;
    logic          set_en, slot_busy;

    hz_scoreboard #(.NREGS(NREGS), .IDXW(IDXW), .LW(LW)) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .set_idx  (id_rd),
        .set_cnt  (lat),
        .rd_a_idx (id_rs1),
        .rd_b_idx (id_rs2),
        .rd_c_idx (id_rd),
        .rd_a_cnt (rs1_cnt),
        .rd_b_cnt (rs2_cnt),
        .rd_c_cnt (rd_cnt)
    );

    hz_wb_slots #(.MAXL(MAXL), .LW(LW)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim_en  (set_en),
        .claim_lat (lat),
        .slot_busy (slot_busy)
    );

    hz_ctrl #(.IDXW(IDXW), .LW(LW), .INT_LAT(INT_LAT), .LONG_LAT(LONG_LAT)) u_ctrl (
        .id_valid       (id_valid),
        .id_class       (id_class),
        .id_rs1         (id_rs1),
        .id_rs1_en      (id_rs1_en),
        .id_rs2         (id_rs2),
        .id_rs2_en      (id_rs2_en),
        .id_rd          (id_rd),
        .ex_br_taken    (ex_br_taken),
        .rs1_cnt        (rs1_cnt),
        .rs2_cnt        (rs2_cnt),
        .rd_cnt         (rd_cnt),
        .slot_busy      (slot_busy),
        .lat            (lat),
        .set_en         (set_en),
        .id_stall       (id_stall),
        .ex_bubble      (ex_bubble),
        .flush_if1      (flush_if1),
        .flush_if2      (flush_if2),
        .flush_id       (flush_id),
        .fetch_redirect (fetch_redirect)
    );

    // R4: an instruction that leaves decode sees both enabled sources in or past writeback.
    a_r4_ready_at_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && !id_stall && !ex_br_taken) |->
        ((!id_rs1_en || id_rs1 == '0 || rs1_cnt <= LW'(1)) &&
         (!id_rs2_en || id_rs2 == '0 || rs2_cnt <= LW'(1))));

    // R7: a stall only ever accompanies a valid instruction and a bubble.
    a_r7_stall_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        id_stall |-> (id_valid && ex_bubble));

    // R9: a squashed decode instruction records no pending write.
    a_r9_no_record_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_id |-> !set_en);

    // R10: a recorded write never lands before an older write to the same register.
    a_r10_write_order: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> (rd_cnt <= lat));

endmodule

// File: tb/hz_interlock_tb_top.sv
// Directed bench: one default copy (both latencies 5) and one with a 7-cycle long path.
module hz_interlock_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       id_valid = 1'b0;
    logic [2:0] id_class = 3'd0;
    logic [4:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
    logic       id_rs1_en = 1'b0, id_rs2_en = 1'b0;
    logic       ex_br_taken = 1'b0;

    logic stall_i, bub_i, fif1_i, fif2_i, fid_i, redir_i;
    logic stall_w, bub_w, fif1_w, fif2_w, fid_w, redir_w;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    hz_interlock dut_i (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_class(id_class),
        .id_rs1(id_rs1), .id_rs1_en(id_rs1_en), .id_rs2(id_rs2), .id_rs2_en(id_rs2_en),
        .id_rd(id_rd), .ex_br_taken(ex_br_taken), .id_stall(stall_i), .ex_bubble(bub_i),
        .flush_if1(fif1_i), .flush_if2(fif2_i), .flush_id(fid_i), .fetch_redirect(redir_i)
    );

    hz_interlock #(.INT_LAT(5), .LONG_LAT(7)) dut_w (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_class(id_class),
        .id_rs1(id_rs1), .id_rs1_en(id_rs1_en), .id_rs2(id_rs2), .id_rs2_en(id_rs2_en),
        .id_rd(id_rd), .ex_br_taken(ex_br_taken), .id_stall(stall_w), .ex_bubble(bub_w),
        .flush_if1(fif1_w), .flush_if2(fif2_w), .flush_id(fid_w), .fetch_redirect(redir_w)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference cycle model: stalls of a reader g issued slots after its producer.
    function automatic int exp_stall(input int lat, input int gap);
        return (lat - 1 - gap > 0) ? (lat - 1 - gap) : 0;
    endfunction

    task automatic idle(input int n);
        id_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Present one instruction at a negedge and wait until it leaves decode.
    task automatic issue(input bit sel, input logic [2:0] cls,
                         input int rs1, input bit e1, input int rs2, input bit e2,
                         input int rd, output int stalls);
        stalls   = 0;
        id_valid = 1'b1;
        id_class = cls;
        id_rs1 = 5'(rs1); id_rs1_en = e1;
        id_rs2 = 5'(rs2); id_rs2_en = e2;
        id_rd  = 5'(rd);
        while (1) begin
            #2;
            if (!(sel ? stall_w : stall_i)) break;
            stalls++;
            chk("R7 bubble with stall", int'(sel ? bub_w : bub_i), 1);
            if (stalls > 40) break;
            @(negedge clk);
        end
        @(negedge clk);
        id_valid = 1'b0;
    endtask

    task automatic t_reset;
        int s;
        chk("R1 stall after reset", int'(stall_i), 0);
        chk("R8 no flush after reset", int'(fid_i | fif1_i | fif2_i | redir_i), 0);
        issue(0, 3'd0, 0, 0, 0, 0, 3, s);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        issue(0, 3'd0, 3, 1, 0, 0, 0, s);
        chk("R1 pending cleared by reset", s, 0);
    endtask

    task automatic t_raw_short;
        int s;
        idle(8);
        issue(0, 3'd0, 0, 0, 0, 0, 3, s);
        issue(0, 3'd0, 3, 1, 0, 0, 0, s);
        chk("R2 arithmetic producer", s, exp_stall(5, 0));
        idle(8);
        issue(0, 3'd1, 0, 0, 0, 0, 4, s);
        issue(0, 3'd2, 0, 0, 4, 1, 0, s);
        chk("R2 load producer, second source", s, exp_stall(5, 0));
    endtask

    task automatic t_raw_long;
        int s;
        idle(10);
        issue(0, 3'd4, 0, 0, 0, 0, 5, s);
        issue(0, 3'd0, 5, 1, 0, 0, 0, s);
        chk("R3 long producer LAT 5", s, exp_stall(5, 0));
        idle(10);
        issue(1, 3'd4, 0, 0, 0, 0, 5, s);
        issue(1, 3'd0, 5, 1, 0, 0, 0, s);
        chk("R3 long producer LAT 7", s, exp_stall(7, 0));
    endtask

    task automatic t_distance;
        int s;
        for (int g = 0; g < 6; g++) begin
            idle(8);
            issue(0, 3'd0, 0, 0, 0, 0, 6, s);
            for (int k = 0; k < g; k++) issue(0, 3'd2, 0, 0, 0, 0, 0, s);
            issue(0, 3'd0, 0, 0, 6, 1, 0, s);
            chk($sformatf("R4 distance %0d", g), s, exp_stall(5, g));
        end
    endtask

    task automatic t_zero;
        int s;
        idle(8);
        issue(0, 3'd0, 0, 0, 0, 0, 0, s);
        issue(0, 3'd0, 0, 1, 0, 1, 0, s);
        chk("R5 register zero", s, 0);
    endtask

    task automatic t_nowrite;
        int s;
        idle(8);
        issue(0, 3'd2, 0, 0, 0, 0, 8, s);
        issue(0, 3'd0, 8, 1, 0, 0, 0, s);
        chk("R6 store records nothing", s, 0);
        issue(0, 3'd3, 0, 0, 0, 0, 9, s);
        issue(0, 3'd0, 9, 1, 0, 0, 0, s);
        chk("R6 branch records nothing", s, 0);
        issue(0, 3'd5, 0, 0, 0, 0, 10, s);
        issue(0, 3'd0, 10, 1, 0, 0, 0, s);
        chk("R6 reserved class records nothing", s, 0);
        issue(0, 3'd0, 0, 0, 0, 0, 11, s);
        issue(0, 3'd0, 11, 0, 11, 0, 0, s);
        chk("R6 disabled sources ignored", s, 0);
    endtask

    task automatic t_invalid;
        int s;
        idle(8);
        issue(0, 3'd0, 0, 0, 0, 0, 12, s);
        id_valid = 1'b0; id_rs1 = 5'd12; id_rs1_en = 1'b1;
        #2;
        chk("R7 invalid slot no stall", int'(stall_i), 0);
        chk("R7 invalid slot no bubble", int'(bub_i), 0);
    endtask

    task automatic t_flush;
        int s;
        idle(8);
        issue(0, 3'd0, 0, 0, 0, 0, 17, s);
        id_valid = 1'b1; id_class = 3'd0; id_rs1 = 5'd17; id_rs1_en = 1'b1; id_rd = '0;
        #2;
        chk("R8 stall before branch", int'(stall_i), 1);
        ex_br_taken = 1'b1;
        #2;
        chk("R8 stall dropped on flush", int'(stall_i), 0);
        chk("R8 flush_if1", int'(fif1_i), 1);
        chk("R8 flush_if2", int'(fif2_i), 1);
        chk("R8 flush_id", int'(fid_i), 1);
        chk("R8 fetch_redirect", int'(redir_i), 1);
        @(negedge clk);
        ex_br_taken = 1'b0;
        id_valid = 1'b0;
        #2;
        chk("R8 flush released", int'(fid_i | fif1_i | fif2_i | redir_i), 0);
    endtask

    task automatic t_squash;
        int s;
        idle(8);
        id_valid = 1'b1; id_class = 3'd0; id_rs1_en = 1'b0; id_rs2_en = 1'b0; id_rd = 5'd20;
        ex_br_taken = 1'b1;
        @(negedge clk);
        ex_br_taken = 1'b0;
        issue(0, 3'd0, 20, 1, 0, 0, 0, s);
        chk("R9 squashed writer leaves nothing", s, 0);
    endtask

    task automatic t_waw;
        int s;
        idle(10);
        issue(1, 3'd4, 0, 0, 0, 0, 13, s);
        issue(1, 3'd0, 0, 0, 0, 0, 13, s);
        chk("R10 short writer behind long writer", s, 2);
    endtask

    task automatic t_port;
        int s;
        idle(10);
        issue(1, 3'd4, 0, 0, 0, 0, 14, s);
        issue(1, 3'd0, 0, 0, 0, 0, 15, s);
        chk("R11 free writeback slot", s, 0);
        issue(1, 3'd0, 0, 0, 0, 0, 16, s);
        chk("R11 reserved writeback slot", s, 1);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raw_short();
        t_raw_long();
        t_distance();
        t_zero();
        t_nowrite();
        t_invalid();
        t_flush();
        t_squash();
        t_waw();
        t_port();
        idle(4);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule